// File: doc/BRIEF.md
# Two-Cluster Register File with One-Way Channel Registers

This block is the register storage for a datapath with two clusters. Each cluster sees sixteen register indices through its own two read ports and one write port. Most of those indices are ordinary local registers. The top few are rewired into one-way channels between the clusters, so values move from one cluster to the other without any extra port and without a cluster-select bit in the operand.

Each channel register is written only by one cluster and read only by the other. From a cluster's point of view, some of its top indices are *import* slots: it reads them, and the peer fills them. The remaining top indices are *export* slots: it writes them, and the peer reads them through its own import slots. Both clusters use the same index layout, so the peer's export slot k and the local import slot k are the same flop.

A write from a cluster to one of its own import slots has no owner on that side. The write is dropped, and a one-cycle error strobe is raised. A cluster that has more values to send than it has export slots must hold them back itself. The block has no queue.

Top module: `dual_cluster_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register to zero. After reset, every index reads zero on all four read ports.
- R2: With G = NUM_REGS - NUM_CHAN, indices 0 to G-1 are local to each cluster. A write to such an index is seen on both read ports of the same cluster from the cycle after the write edge. It never changes what the other cluster reads at that index.
- R3: With H = NUM_CHAN/2, indices G+H to NUM_REGS-1 are export slots. A write by cluster A to index G+H+k is read by cluster B at import index G+k from the next cycle on. The same holds with A and B swapped.
- R4: Indices G to G+H-1 are import slots. A write by a cluster to its own import slot leaves all storage unchanged. The write error output of that cluster goes high in the cycle after the write edge, and only for that one cycle.
- R5: A cluster that reads one of its own export slots gets zero.
- R6: There is no write-to-read bypass. A read in the same cycle as a write to the same register returns the value held before the write edge.
- R7: There is no limit on channel traffic per cycle. All four read ports may read channel registers in the same cycle, and both clusters may write their export slots in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_rd0_idx | input | 4 | Cluster A read port 0 index |
| a_rd0_data | output | 32 | Cluster A read port 0 data |
| a_rd1_idx | input | 4 | Cluster A read port 1 index |
| a_rd1_data | output | 32 | Cluster A read port 1 data |
| a_wr_en | input | 1 | Cluster A write enable |
| a_wr_idx | input | 4 | Cluster A write index |
| a_wr_data | input | 32 | Cluster A write data |
| a_wr_err | output | 1 | Cluster A wrote its own import slot last cycle |
| b_rd0_idx | input | 4 | Cluster B read port 0 index |
| b_rd0_data | output | 32 | Cluster B read port 0 data |
| b_rd1_idx | input | 4 | Cluster B read port 1 index |
| b_rd1_data | output | 32 | Cluster B read port 1 data |
| b_wr_en | input | 1 | Cluster B write enable |
| b_wr_idx | input | 4 | Cluster B write index |
| b_wr_data | input | 32 | Cluster B write data |
| b_wr_err | output | 1 | Cluster B wrote its own import slot last cycle |

## Verification
The bench builds the block with its defaults: 16 indices, 4 channel registers and 32-bit data. That gives local indices 0 to 11, import slots 12 and 13, and export slots 14 and 15. Both channel slots in each direction are therefore reachable. So are the boundaries between the three regions at indices 11/12, 13/14 and 15. This lets the bench cross-check, slot by slot, that an export write lands on the peer's matching import slot. It also checks that a stray import write corrupts neither of the two physical channel flops it could alias.

// File: rtl/rfx_pkg.sv
package rfx_pkg;

    typedef enum logic [1:0] {
        SLOT_LOCAL  = 2'd0,
        SLOT_IMPORT = 2'd1,
        SLOT_EXPORT = 2'd2
    } slot_kind_e;

endpackage

// File: rtl/rfx_index_decode.sv
module rfx_index_decode
    import rfx_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int NUM_CHAN = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0] idx,
    output slot_kind_e       kind,
    output logic [IDX_W-1:0] off
);
    localparam int NUM_LOCAL = NUM_REGS - NUM_CHAN;
    localparam int NUM_IMP   = NUM_CHAN / 2;
    localparam logic [IDX_W-1:0] IMP_BASE = IDX_W'(NUM_LOCAL);
    localparam logic [IDX_W-1:0] EXP_BASE = IDX_W'(NUM_LOCAL + NUM_IMP);

    always_comb begin
        if (idx < IMP_BASE) begin
            kind = SLOT_LOCAL;
            off  = idx;
        end else if (idx < EXP_BASE) begin
            kind = SLOT_IMPORT;
            off  = idx - IMP_BASE;
        end else begin
            kind = SLOT_EXPORT;
            off  = idx - EXP_BASE;
        end
    end
endmodule

// File: rtl/rfx_storage.sv
module rfx_storage #(
    parameter int DEPTH  = 12,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            waddr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DEPTH-1:0][DATA_W-1:0] q
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= '0;
            end else if (we && (waddr == ADDR_W'(i))) begin
                q[i] <= wdata;
            end
        end
    end

    // Without a write enable no cell of this bank may change.
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/rfx_read_port.sv
module rfx_read_port
    import rfx_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int NUM_CHAN = 4,
    parameter int DATA_W   = 32,
    localparam int IDX_W     = $clog2(NUM_REGS),
    localparam int NUM_LOCAL = NUM_REGS - NUM_CHAN,
    localparam int NUM_IMP   = NUM_CHAN / 2
) (
    input  logic [IDX_W-1:0]                 idx,
    input  logic [NUM_LOCAL-1:0][DATA_W-1:0] local_q,
    input  logic [NUM_IMP-1:0][DATA_W-1:0]   import_q,
    output logic [DATA_W-1:0]                data
);
    slot_kind_e       kind;
    logic [IDX_W-1:0] off;

    rfx_index_decode #(
        .NUM_REGS (NUM_REGS),
        .NUM_CHAN (NUM_CHAN)
    ) u_dec (
        .idx  (idx),
        .kind (kind),
        .off  (off)
    );

    always_comb begin
        data = '0;
        unique case (kind)
            SLOT_LOCAL: begin
                for (int i = 0; i < NUM_LOCAL; i++) begin
                    if (off == IDX_W'(i)) data = local_q[i];
                end
            end
            SLOT_IMPORT: begin
                for (int i = 0; i < NUM_IMP; i++) begin
                    if (off == IDX_W'(i)) data = import_q[i];
                end
            end
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/dual_cluster_regfile.sv
module dual_cluster_regfile
    import rfx_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int NUM_CHAN = 4,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  a_rd0_idx,
    output logic [DATA_W-1:0] a_rd0_data,
    input  logic [IDX_W-1:0]  a_rd1_idx,
    output logic [DATA_W-1:0] a_rd1_data,
    input  logic              a_wr_en,
    input  logic [IDX_W-1:0]  a_wr_idx,
    input  logic [DATA_W-1:0] a_wr_data,
    output logic              a_wr_err,
    input  logic [IDX_W-1:0]  b_rd0_idx,
    output logic [DATA_W-1:0] b_rd0_data,
    input  logic [IDX_W-1:0]  b_rd1_idx,
    output logic [DATA_W-1:0] b_rd1_data,
    input  logic              b_wr_en,
    input  logic [IDX_W-1:0]  b_wr_idx,
    input  logic [DATA_W-1:0] b_wr_data,
    output logic              b_wr_err
);
    localparam int NUM_LOCAL = NUM_REGS - NUM_CHAN;
    localparam int NUM_IMP   = NUM_CHAN / 2;
    localparam logic [IDX_W-1:0] IMP_BASE = IDX_W'(NUM_LOCAL);
    localparam logic [IDX_W-1:0] EXP_BASE = IDX_W'(NUM_LOCAL + NUM_IMP);
    localparam logic [IDX_W-1:0] HALF     = IDX_W'(NUM_IMP);

    // Index 0 is cluster A, index 1 is cluster B.
    logic [1:0]                          wr_en;
    logic [1:0][IDX_W-1:0]               wr_idx;
    logic [1:0][DATA_W-1:0]              wr_data;
    logic [1:0][1:0][IDX_W-1:0]          rd_idx;
    logic [1:0][1:0][DATA_W-1:0]         rd_data;
    logic [1:0]                          err_q;
    logic [1:0][NUM_LOCAL-1:0][DATA_W-1:0] gpr_q;
    // chan_q[c] is written by cluster c and read by its peer.
    logic [1:0][NUM_IMP-1:0][DATA_W-1:0]   chan_q;

    assign wr_en   = {b_wr_en,   a_wr_en};
    assign wr_idx  = {b_wr_idx,  a_wr_idx};
    assign wr_data = {b_wr_data, a_wr_data};
    assign rd_idx  = {{b_rd1_idx, b_rd0_idx}, {a_rd1_idx, a_rd0_idx}};

    assign a_rd0_data = rd_data[0][0];
    assign a_rd1_data = rd_data[0][1];
    assign b_rd0_data = rd_data[1][0];
    assign b_rd1_data = rd_data[1][1];
    assign a_wr_err   = err_q[0];
    assign b_wr_err   = err_q[1];

    for (genvar c = 0; c < 2; c++) begin : g_cluster
        localparam int PEER = 1 - c;

        slot_kind_e       wkind;
        logic [IDX_W-1:0] woff;
        logic             gpr_we;
        logic             chan_we;

        rfx_index_decode #(
            .NUM_REGS (NUM_REGS),
            .NUM_CHAN (NUM_CHAN)
        ) u_wdec (
            .idx  (wr_idx[c]),
            .kind (wkind),
            .off  (woff)
        );

        always_comb begin
            gpr_we  = 1'b0;
            chan_we = 1'b0;
            unique case (wkind)
                SLOT_LOCAL:  gpr_we  = wr_en[c];
                SLOT_EXPORT: chan_we = wr_en[c];
                default: ;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) err_q[c] <= 1'b0;
            else     err_q[c] <= wr_en[c] && (wkind == SLOT_IMPORT);
        end

        rfx_storage #(
            .DEPTH  (NUM_LOCAL),
            .DATA_W (DATA_W),
            .ADDR_W (IDX_W)
        ) u_gpr (
            .clk   (clk),
            .rst   (rst),
            .we    (gpr_we),
            .waddr (woff),
            .wdata (wr_data[c]),
            .q     (gpr_q[c])
        );

        rfx_storage #(
            .DEPTH  (NUM_IMP),
            .DATA_W (DATA_W),
            .ADDR_W (IDX_W)
        ) u_chan (
            .clk   (clk),
            .rst   (rst),
            .we    (chan_we),
            .waddr (woff),
            .wdata (wr_data[c]),
            .q     (chan_q[c])
        );

        for (genvar p = 0; p < 2; p++) begin : g_rport
            rfx_read_port #(
                .NUM_REGS (NUM_REGS),
                .NUM_CHAN (NUM_CHAN),
                .DATA_W   (DATA_W)
            ) u_rd (
                .idx      (rd_idx[c][p]),
                .local_q  (gpr_q[c]),
                .import_q (chan_q[PEER]),
                .data     (rd_data[c][p])
            );
        end
    end

    // ---------------- port-level properties ----------------
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (a_rd0_data == '0 && a_rd1_data == '0 &&
                        b_rd0_data == '0 && b_rd1_data == '0));

    assert_local_visible_R2: assert property (@(posedge clk) disable iff (rst)
        (a_wr_en && a_wr_idx < IMP_BASE) |=>
        (a_rd1_idx != $past(a_wr_idx) || a_rd1_data == $past(a_wr_data)));

    assert_chan_a_to_b_R3: assert property (@(posedge clk) disable iff (rst)
        (a_wr_en && a_wr_idx >= EXP_BASE) |=>
        (b_rd0_idx != $past(a_wr_idx) - HALF || b_rd0_data == $past(a_wr_data)));

    assert_chan_b_to_a_R3: assert property (@(posedge clk) disable iff (rst)
        (b_wr_en && b_wr_idx >= EXP_BASE) |=>
        (a_rd0_idx != $past(b_wr_idx) - HALF || a_rd0_data == $past(b_wr_data)));

    assert_import_write_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (a_wr_en && a_wr_idx >= IMP_BASE && a_wr_idx < EXP_BASE) |=> a_wr_err);

    assert_flag_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !(b_wr_en && b_wr_idx >= IMP_BASE && b_wr_idx < EXP_BASE) |=> !b_wr_err);

    assert_own_export_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (a_rd0_idx >= EXP_BASE) |-> (a_rd0_data == '0));

endmodule

// File: tb/dual_cluster_regfile_tb.sv
module dual_cluster_regfile_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  a_rd0_idx = '0, a_rd1_idx = '0, a_wr_idx = '0;
    logic [3:0]  b_rd0_idx = '0, b_rd1_idx = '0, b_wr_idx = '0;
    logic [31:0] a_rd0_data, a_rd1_data, b_rd0_data, b_rd1_data;
    logic [31:0] a_wr_data = '0, b_wr_data = '0;
    logic        a_wr_en = 1'b0, b_wr_en = 1'b0;
    logic        a_wr_err, b_wr_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_cluster_regfile u_dut (
        .clk(clk), .rst(rst),
        .a_rd0_idx(a_rd0_idx), .a_rd0_data(a_rd0_data),
        .a_rd1_idx(a_rd1_idx), .a_rd1_data(a_rd1_data),
        .a_wr_en(a_wr_en), .a_wr_idx(a_wr_idx), .a_wr_data(a_wr_data), .a_wr_err(a_wr_err),
        .b_rd0_idx(b_rd0_idx), .b_rd0_data(b_rd0_data),
        .b_rd1_idx(b_rd1_idx), .b_rd1_data(b_rd1_data),
        .b_wr_en(b_wr_en), .b_wr_idx(b_wr_idx), .b_wr_data(b_wr_data), .b_wr_err(b_wr_err)
    );

    typedef struct packed {
        logic        awe;  logic [3:0] awi; logic [31:0] awd;
        logic        bwe;  logic [3:0] bwi; logic [31:0] bwd;
        logic [3:0]  ari;  logic [31:0] aexp;
        logic [3:0]  bri;  logic [31:0] bexp;
        logic        aerr; logic        berr;
    } vec_t;

    function automatic vec_t mk(logic awe, logic [3:0] awi, logic [31:0] awd,
                                logic bwe, logic [3:0] bwi, logic [31:0] bwd,
                                logic [3:0] ari, logic [31:0] aexp,
                                logic [3:0] bri, logic [31:0] bexp,
                                logic aerr, logic berr);
        return '{awe, awi, awd, bwe, bwi, bwd, ari, aexp, bri, bexp, aerr, berr};
    endfunction

    // Layout with defaults: local 0..11, import 12..13, export 14..15.
    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        mk(1, 4'd3,  32'h1111_1111, 1, 4'd3,  32'h2222_2222, 4'd3,  32'h1111_1111, 4'd3,  32'h2222_2222, 0, 0),
        mk(1, 4'd14, 32'hAAAA_0001, 0, 4'd0,  32'h0,         4'd12, 32'h0,         4'd12, 32'hAAAA_0001, 0, 0),
        mk(1, 4'd15, 32'hAAAA_0003, 1, 4'd15, 32'hBBBB_0002, 4'd13, 32'hBBBB_0002, 4'd13, 32'hAAAA_0003, 0, 0),
        mk(1, 4'd12, 32'hDEAD_0000, 0, 4'd0,  32'h0,         4'd12, 32'h0,         4'd14, 32'h0,         1, 0),
        mk(0, 4'd0,  32'h0,         1, 4'd13, 32'hDEAD_0001, 4'd14, 32'h0,         4'd13, 32'hAAAA_0003, 0, 1),
        mk(1, 4'd0,  32'h0000_00F0, 0, 4'd0,  32'h0,         4'd15, 32'h0,         4'd0,  32'h0,         0, 0),
        mk(0, 4'd0,  32'h0,         1, 4'd14, 32'h1234_5678, 4'd12, 32'h1234_5678, 4'd12, 32'hAAAA_0001, 0, 0),
        mk(1, 4'd11, 32'hFFFF_FFFF, 0, 4'd0,  32'h0,         4'd11, 32'hFFFF_FFFF, 4'd11, 32'h0,         0, 0)
    };
    string vtag [NV] = '{"R2", "R3", "R3/R7", "R4/R5", "R4/R5", "R5/R2", "R3", "R2"};

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic idle_writes();
        a_wr_en = 1'b0;
        b_wr_en = 1'b0;
    endtask

    task automatic all_zero(string req);
        for (int i = 0; i < 16; i++) begin
            a_rd0_idx = 4'(i); a_rd1_idx = 4'(i);
            b_rd0_idx = 4'(i); b_rd1_idx = 4'(i);
            #1;
            check(req, a_rd0_data, 32'h0);
            check(req, a_rd1_data, 32'h0);
            check(req, b_rd0_data, 32'h0);
            check(req, b_rd1_data, 32'h0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: every index reads zero after reset.
        all_zero("R1 reset");
        check("R1 err A", {31'h0, a_wr_err}, 32'h0);
        check("R1 err B", {31'h0, b_wr_err}, 32'h0);

        // Vector table: write at one edge, read just after it.
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            a_wr_en = VEC[v].awe; a_wr_idx = VEC[v].awi; a_wr_data = VEC[v].awd;
            b_wr_en = VEC[v].bwe; b_wr_idx = VEC[v].bwi; b_wr_data = VEC[v].bwd;
            a_rd0_idx = VEC[v].ari; a_rd1_idx = VEC[v].ari;
            b_rd0_idx = VEC[v].bri; b_rd1_idx = VEC[v].bri;
            @(posedge clk);
            #1;
            check(vtag[v], a_rd0_data, VEC[v].aexp);
            check(vtag[v], a_rd1_data, VEC[v].aexp);
            check(vtag[v], b_rd0_data, VEC[v].bexp);
            check(vtag[v], b_rd1_data, VEC[v].bexp);
            check({vtag[v], " err A"}, {31'h0, a_wr_err}, {31'h0, VEC[v].aerr});
            check({vtag[v], " err B"}, {31'h0, b_wr_err}, {31'h0, VEC[v].berr});
        end
        @(negedge clk);
        idle_writes();

        // R7: four ports read four channel registers in one cycle.
        a_rd0_idx = 4'd12; a_rd1_idx = 4'd13;
        b_rd0_idx = 4'd12; b_rd1_idx = 4'd13;
        #1;
        check("R7 A imp0", a_rd0_data, 32'h1234_5678);
        check("R7 A imp1", a_rd1_data, 32'hBBBB_0002);
        check("R7 B imp0", b_rd0_data, 32'hAAAA_0001);
        check("R7 B imp1", b_rd1_data, 32'hAAAA_0003);
        check("R4 err pulse width", {31'h0, a_wr_err | b_wr_err}, 32'h0);

        // R6: same-cycle read returns the old value, new value after the edge.
        @(negedge clk);
        a_wr_en = 1'b1; a_wr_idx = 4'd5;  a_wr_data = 32'h0000_0055;
        b_wr_en = 1'b1; b_wr_idx = 4'd15; b_wr_data = 32'hCAFE_0007;
        a_rd0_idx = 4'd5; a_rd1_idx = 4'd13;
        #1;
        check("R6 A old", a_rd0_data, 32'h0);
        check("R6 A chan old", a_rd1_data, 32'hBBBB_0002);
        @(posedge clk);
        #1;
        check("R6 A new", a_rd0_data, 32'h0000_0055);
        check("R6 A chan new", a_rd1_data, 32'hCAFE_0007);
        @(negedge clk);
        idle_writes();

        // R1: reset in mid-run clears everything again.
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        all_zero("R1 rerun");

        done = 1'b1;
        report();
        $finish;
    end
endmodule